// File: doc/BRIEF.md
# Burst-of-Four Byte-Masked SRAM Write Path

This block is the write front end of a synchronous word-wide memory. A single write command carrying an address opens a burst of four data beats, and each beat lands in its own word of an aligned group of four consecutive words. A beat is one 18-bit word seen as two 9-bit lanes, and each lane comes with an active-low enable that is sampled together with the data on the same clock edge. When a lane's enable is high, that lane of the target word keeps the value it already held.

While a burst is in progress the block shows `busy`. A command presented during a burst is dropped, and a one-cycle `cmdError` pulse reports it. A separate read port returns any stored word one clock after its address is sampled, so a testbench can compare the memory contents against its own model.

Top module: `burst_wr_sram`

## Requirements
- R1: A command sampled while `busy` is low is accepted. The four data beats are then sampled on the four rising edges after the accepting edge, and `busy` is high for exactly those four cycles.
- R2: Beat n of a burst (n = 0..3) is written to the word at base address + n.
- R3: The two low bits of `cmdAddr` are ignored, so the base address is always a multiple of four.
- R4: `beatByteEnN[0]` low writes data bits 8:0, and `beatByteEnN[1]` low writes data bits 17:9.
- R5: A lane whose enable is high on a beat leaves that lane of the target word unchanged.
- R6: Every combination of the two enables is honoured on every beat independently, including both lanes written and both lanes masked.
- R7: A command sampled while `busy` is high causes `cmdError` to be high for the next cycle only. It does not change the burst in progress and starts no burst of its own.
- R8: `rdData` shows the word stored at `rdAddr` one cycle after `rdAddr` is sampled.
- R9: After reset, `busy` and `cmdError` are low.
- R10: Data and enables presented outside a burst change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Write command request |
| cmdAddr | input | ADDR_W | Command address; the two low bits are ignored |
| beatData | input | 18 | Data for the current beat |
| beatByteEnN | input | 2 | Active-low lane enables for the current beat |
| rdAddr | input | ADDR_W | Read-back address |
| rdData | output | 18 | Read-back word, one cycle latency |
| busy | output | 1 | A burst is in progress |
| cmdError | output | 1 | One-cycle pulse for a command that was refused |

## Verification
`busy` rises one cycle after the accepting edge. Beat k (k = 1..4) is sampled on the k-th rising edge after that edge, and `cmdError` is valid in the cycle after the refused command. The bench changes inputs on falling edges and reads outputs at the falling edge that follows the edge of interest. Read-back samples `rdData` one full cycle after `rdAddr` is set, and it only reads words that no write touches on that edge.

// File: rtl/burst_wr_pkg.sv
package burst_wr_pkg;
  parameter int BURST_LEN = 4;
  localparam int BEAT_W = $clog2(BURST_LEN);

  typedef struct packed {
    logic              wrEn;
    logic [BEAT_W-1:0] beatIdx;
  } wrStrobe_t;
endpackage

// File: rtl/burst_wr_ctrl.sv
module burst_wr_ctrl
  import burst_wr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  output wrStrobe_t         strobe,
  output logic [ADDR_W-1:0] baseAddr,
  output logic              busy,
  output logic              cmdError
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  logic [BEAT_W-1:0] beatCnt;
  logic accept;

  assign accept = cmdValid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cmdError <= 1'b0;
      beatCnt  <= '0;
      baseAddr <= '0;
    end else begin
      cmdError <= cmdValid && busy;
      if (accept) begin
        busy     <= 1'b1;
        beatCnt  <= '0;
        baseAddr <= {cmdAddr[ADDR_W-1:BEAT_W], {BEAT_W{1'b0}}};
      end else if (busy) begin
        beatCnt <= beatCnt + 1'b1;
        if (beatCnt == LAST_BEAT) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.wrEn    = busy;
    strobe.beatIdx = beatCnt;
  end
endmodule

// File: rtl/burst_wr_datapath.sv
module burst_wr_datapath
  import burst_wr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2,
  localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  wrStrobe_t            strobe,
  input  logic [ADDR_W-1:0]    baseAddr,
  input  logic [WORD_W-1:0]    beatData,
  input  logic [NUM_BYTES-1:0] beatByteEnN,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [WORD_W-1:0]    rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] wrAddr;
  assign wrAddr = baseAddr | ADDR_W'(strobe.beatIdx);

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] laneMem [DEPTH];
    logic [BYTE_W-1:0] laneRd;

    always_ff @(posedge clk) begin
      if (strobe.wrEn && !beatByteEnN[b])
        laneMem[wrAddr] <= beatData[b*BYTE_W +: BYTE_W];
      laneRd <= laneMem[rdAddr];
    end

    assign rdData[b*BYTE_W +: BYTE_W] = laneRd;
  end
endmodule

// File: rtl/burst_wr_sram.sv
module burst_wr_sram
  import burst_wr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BYTE_W    = 9,
  parameter int NUM_BYTES = 2,
  localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmdValid,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [WORD_W-1:0]    beatData,
  input  logic [NUM_BYTES-1:0] beatByteEnN,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [WORD_W-1:0]    rdData,
  output logic                 busy,
  output logic                 cmdError
);
  wrStrobe_t         strobe;
  logic [ADDR_W-1:0] baseAddr;

  burst_wr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .strobe(strobe), .baseAddr(baseAddr), .busy(busy), .cmdError(cmdError)
  );

  burst_wr_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_dp (
    .clk(clk), .strobe(strobe), .baseAddr(baseAddr), .beatData(beatData),
    .beatByteEnN(beatByteEnN), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/burst_wr_sram_checker.sv
module burst_wr_sram_checker #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [WORD_W-1:0] rdData,
  input logic              busy,
  input logic              cmdError
);
  AST_BUSY_FOUR_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy); // R1

  AST_ERR_ON_BUSY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && busy) |=> cmdError); // R7

  AST_NO_ERR_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy) |=> !cmdError); // R7

  AST_BUSY_CMD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && busy && $past(busy) && $past(busy, 2) && $past(busy, 3)) |=> !busy); // R7

  AST_IDLE_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(rdAddr)) |=> $stable(rdData)); // R10
endmodule

bind burst_wr_sram burst_wr_sram_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .rdAddr(rdAddr),
  .rdData(rdData), .busy(busy), .cmdError(cmdError)
);

// File: tb/burst_wr_sram_test.sv
module burst_wr_sram_test;
  localparam int ADDR_W = 8;
  localparam int W      = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmdValid = 1'b0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [W-1:0]  beatData = '0;
  logic [1:0]    beatByteEnN = 2'b11;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [W-1:0]  rdData;
  logic          busy, cmdError;

  logic [W-1:0] model [1 << ADDR_W];
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  burst_wr_sram uut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .beatData(beatData), .beatByteEnN(beatByteEnN), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy), .cmdError(cmdError)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] d, logic [1:0] en);
    merge = old;
    if (!en[0]) merge[8:0]  = d[8:0];
    if (!en[1]) merge[17:9] = d[17:9];
  endfunction

  // Burst with optional refused command injected on beat index errBeat (-1 = none)
  task automatic burst(logic [ADDR_W-1:0] a, logic [W-1:0] d[4], logic [1:0] en[4],
                       int errBeat, string req);
    logic [ADDR_W-1:0] base;
    base = {a[ADDR_W-1:2], 2'b00};
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = a;
    @(negedge clk);
    chk({req, " R1 busy"}, W'(busy), W'(1));
    for (int n = 0; n < 4; n++) begin
      beatData = d[n]; beatByteEnN = en[n];
      cmdValid = (n == errBeat); cmdAddr = a ^ 8'h40;
      @(negedge clk);
      if (n == errBeat) chk("R7 error pulse", W'(cmdError), W'(1));
      if (n == errBeat + 1 && errBeat >= 0) chk("R7 pulse one cycle", W'(cmdError), W'(0));
      model[base + n] = merge(model[base + n], d[n], en[n]);
    end
    chk({req, " R1 busy low after four beats"}, W'(busy), W'(0));
    cmdValid = 1'b0; beatByteEnN = 2'b11; beatData = '0;
  endtask

  task automatic readChk(logic [ADDR_W-1:0] a, string req);
    @(negedge clk);
    rdAddr = a;
    @(negedge clk);
    chk(req, rdData, model[a]);
  endtask

  task automatic testReset();
    chk("R9 busy after reset", W'(busy), W'(0));
    chk("R9 cmdError after reset", W'(cmdError), W'(0));
  endtask

  task automatic testFill();
    logic [W-1:0] d[4];
    logic [1:0] en[4] = '{2'b00, 2'b00, 2'b00, 2'b00};
    for (int g = 0; g < 4; g++) begin
      for (int n = 0; n < 4; n++) d[n] = W'(18'h10000 + g * 16 + n * 257);
      burst(8'(g * 4), d, en, -1, "fill");
    end
    for (int w = 0; w < 16; w++) readChk(8'(w), "R2 R8 full-word burst");
  endtask

  task automatic testMaskPattern();
    logic [W-1:0] d[4] = '{18'h3FFFF, 18'h2AAAA, 18'h15555, 18'h0F0F0};
    logic [1:0] en[4] = '{2'b10, 2'b01, 2'b00, 2'b01};
    burst(8'h04, d, en, -1, "mask");
    for (int w = 4; w < 8; w++) readChk(8'(w), "R4 R5 lane mask pattern");
  endtask

  task automatic testAllMasked();
    logic [W-1:0] d[4] = '{18'h11111, 18'h22222, 18'h33333, 18'h00000};
    logic [1:0] en[4] = '{2'b11, 2'b00, 2'b11, 2'b10};
    burst(8'h0B, d, en, -1, "R3 unaligned");
    for (int w = 8; w < 12; w++) readChk(8'(w), "R3 R6 unaligned and fully masked beats");
    readChk(8'h0C, "R3 neighbour group untouched");
  endtask

  task automatic testBusyCmd();
    logic [W-1:0] d[4] = '{18'h0ABCD, 18'h1BCDE, 18'h2CDEF, 18'h3DEF0};
    logic [1:0] en[4] = '{2'b00, 2'b00, 2'b00, 2'b00};
    burst(8'h01, d, en, 1, "R7");
    for (int w = 0; w < 4; w++) readChk(8'(w), "R7 burst unaffected by refused command");
    for (int w = 64; w < 68; w++) readChk(8'(w), "R7 refused address untouched");
  endtask

  task automatic testIdleData();
    @(negedge clk);
    beatData = 18'h3FFFF; beatByteEnN = 2'b00;
    for (int i = 0; i < 4; i++) begin
      cmdAddr = 8'(i * 4);
      @(negedge clk);
    end
    beatByteEnN = 2'b11;
    for (int w = 0; w < 16; w++) readChk(8'(w), "R10 idle data ignored");
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = 'x;
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testFill();
    testMaskPattern();
    testAllMasked();
    testBusyCmd();
    testIdleData();
    testFill();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule